// File: doc/BRIEF.md
# Composable Multi-Bank RAM Address Mapper

This block joins a set of identical single-port RAM banks into one logical memory. The `interleave` input picks one of two placements. When it is high, consecutive logical words rotate across the banks, so one row of all banks forms a single wide word. When it is low, the banks are stacked end to end into a deeper memory. The banks belong to a run of consecutive global bank numbers that starts at a base number set by a parameter. At most 64 banks can be joined.

A transfer engine fills the memory through a byte stream. A start pulse loads a 16-bit logical word address. The block then packs the incoming bytes into bank-wide words, steers each word to its bank and in-bank row, and steps the address after every word. A read port takes a logical address. One cycle later it returns the addressed word, the global number of the bank that held it, and the full bank row that contains it. In interleave mode that row is the wide word.

The mode must stay constant while the memory holds data that will be read back.

Top module: `bank_compose_mapper`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid`, `rd_err`, `wr_done` and `wr_err` are low and `rd_data` and `rd_row` are zero.
- R2: Every `BYTES_PER_WORD` accepted bytes form one word. The first byte goes into bits [7:0], the next into [15:8], and so on. The words of one transfer go to consecutive logical addresses starting at `xfer_addr`. A `xfer_start` pulse discards any partly assembled word. A byte that arrives in the same cycle as `xfer_start` is the first byte of the new transfer.
- R3: With `interleave` high, logical word address `a` lives in bank `a mod NUM_BANKS` at row `a / NUM_BANKS`. On `rd_row`, bank k occupies bits [k*BANK_W +: BANK_W]. A read of `a` therefore returns the wide word holding logical words `row*NUM_BANKS` to `row*NUM_BANKS+NUM_BANKS-1`, with the lowest address in the low bits.
- R4: With `interleave` low, address `a` lives in bank `a / BANK_DEPTH` at row `a mod BANK_DEPTH`. `rd_row` then holds, for bank k, logical word `k*BANK_DEPTH + row`.
- R5: A word whose logical address is at or beyond `NUM_BANKS*BANK_DEPTH` is not written to any bank, including the bank that a truncated address would alias to. `wr_err` pulses one cycle after the word is formed, and the address still advances.
- R6: A read of an address at or beyond the capacity returns `rd_valid` and `rd_err` high with `rd_data` and `rd_row` zero.
- R7: `rd_valid` is high exactly in the cycle after an accepted `rd_en`, and `rd_data` then holds the word last written to that address.
- R8: When a packed word is being written in the same cycle as `rd_en`, the write takes the banks and the read is dropped: `rd_valid` stays low in the next cycle.
- R9: `rd_bank_id` equals `BASE_ID` plus the index of the bank that held the word that was read.
- R10: `wr_done` pulses one cycle after an in-range word is formed, and the word is readable from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| interleave | input | 1 | 1: words striped across banks, 0: banks stacked |
| xfer_start | input | 1 | Starts a transfer at `xfer_addr` |
| xfer_addr | input | 16 | Logical word address of the first word of a transfer |
| byte_valid | input | 1 | A stream byte is present |
| byte_data | input | 8 | Stream byte |
| wr_done | output | 1 | A packed word was written |
| wr_err | output | 1 | A packed word fell outside the capacity and was dropped |
| rd_en | input | 1 | Read request |
| rd_addr | input | 16 | Logical word address to read |
| rd_valid | output | 1 | Read result present |
| rd_err | output | 1 | Read address was out of range |
| rd_data | output | BANK_W | Word that was read |
| rd_row | output | NUM_BANKS*BANK_W | All banks at the row that was read |
| rd_bank_id | output | 8 | Global number of the bank that was read |

## Verification
The bench fills the whole capacity and reads every address back in both modes. A mapper with the bank and row roles swapped, or a wrong modulus, returns the wrong word and a wrong bank number in at least one of the two sweeps. Writes that cross the top of the capacity are checked for dropping: a mapper that merely truncates the address would overwrite word 0, and that read-back fails. The bench also restarts a transfer in the middle of a word, which catches a packer that keeps the stale byte. Finally it collides a read with a write, where a design that lets the read win would report `rd_valid` or lose the write.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  localparam int unsigned LADDR_W    = 16;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned BANK_LIMIT = 64;
  localparam int unsigned BANKID_W   = 8;
  typedef logic [LADDR_W-1:0] laddr_t;
endpackage

// File: rtl/bcm_addr_map.sv
module bcm_addr_map
  import bcm_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned BANK_DEPTH = 16,
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned ROW_W = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1
) (
  input  logic             interleave,
  input  laddr_t           addr,
  output logic [IDX_W-1:0] bank_idx,
  output logic [ROW_W-1:0] row,
  output logic             out_of_range
);
  localparam laddr_t                 NB_L  = LADDR_W'(NUM_BANKS);
  localparam laddr_t                 DP_L  = LADDR_W'(BANK_DEPTH);
  localparam logic [LADDR_W:0]       CAP_L = (LADDR_W+1)'(NUM_BANKS * BANK_DEPTH);

  always_comb begin
    out_of_range = {1'b0, addr} >= CAP_L;
    if (interleave) begin
      bank_idx = IDX_W'(addr % NB_L);
      row      = ROW_W'(addr / NB_L);
    end else begin
      bank_idx = IDX_W'(addr / DP_L);
      row      = ROW_W'(addr % DP_L);
    end
  end
endmodule

// File: rtl/bcm_bank.sv
module bcm_bank #(
  parameter int unsigned BANK_W     = 16,
  parameter int unsigned BANK_DEPTH = 16,
  localparam int unsigned ROW_W = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] rdata
);
  logic [BANK_W-1:0] mem_q [BANK_DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem_q[row] <= wdata;
      else    rdata      <= mem_q[row];
    end
  end
endmodule

// File: rtl/bcm_packer.sv
module bcm_packer
  import bcm_pkg::*;
#(
  parameter int unsigned BANK_W = 16,
  localparam int unsigned BPW    = BANK_W / BYTE_W,
  localparam int unsigned LANE_W = (BPW > 1) ? $clog2(BPW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  laddr_t            start_addr,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              word_valid,
  output laddr_t            word_addr,
  output logic [BANK_W-1:0] word_data
);
  logic [LANE_W-1:0] lane_q, lane_n, lane_base;
  laddr_t            addr_q, addr_n, addr_base;
  logic [BANK_W-1:0] buf_q, buf_n;
  logic              wv_n;

  always_comb begin
    lane_base = start ? '0 : lane_q;
    addr_base = start ? start_addr : addr_q;
    buf_n     = buf_q;
    lane_n    = lane_base;
    addr_n    = addr_base;
    wv_n      = 1'b0;
    if (byte_valid) begin
      buf_n[lane_base*BYTE_W +: BYTE_W] = byte_data;
      if (lane_base == LANE_W'(BPW-1)) begin
        wv_n   = 1'b1;
        lane_n = '0;
        addr_n = addr_base + 1'b1;
      end else begin
        lane_n = lane_base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q     <= '0;
      addr_q     <= '0;
      word_valid <= 1'b0;
    end else begin
      lane_q     <= lane_n;
      addr_q     <= addr_n;
      word_valid <= wv_n;
    end
  end

  always_ff @(posedge clk) begin
    if (byte_valid) buf_q <= buf_n;
    if (wv_n) begin
      word_addr <= addr_base;
      word_data <= buf_n;
    end
  end
endmodule

// File: rtl/bank_compose_mapper.sv
module bank_compose_mapper
  import bcm_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned BANK_DEPTH = 16,
  parameter int unsigned BANK_W     = 16,
  parameter int unsigned BASE_ID    = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        interleave,
  input  logic                        xfer_start,
  input  logic [15:0]                 xfer_addr,
  input  logic                        byte_valid,
  input  logic [7:0]                  byte_data,
  output logic                        wr_done,
  output logic                        wr_err,
  input  logic                        rd_en,
  input  logic [15:0]                 rd_addr,
  output logic                        rd_valid,
  output logic                        rd_err,
  output logic [BANK_W-1:0]           rd_data,
  output logic [NUM_BANKS*BANK_W-1:0] rd_row,
  output logic [7:0]                  rd_bank_id
);
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned ROW_W = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;

  logic              pk_valid;
  laddr_t            pk_addr;
  logic [BANK_W-1:0] pk_data;

  bcm_packer #(.BANK_W(BANK_W)) packer_i (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .start_addr(xfer_addr),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .word_valid(pk_valid), .word_addr(pk_addr), .word_data(pk_data)
  );

  logic [IDX_W-1:0] w_idx, r_idx;
  logic [ROW_W-1:0] w_row, r_row;
  logic             w_oor, r_oor;

  bcm_addr_map #(.NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH)) wmap_i (
    .interleave(interleave), .addr(pk_addr),
    .bank_idx(w_idx), .row(w_row), .out_of_range(w_oor)
  );
  bcm_addr_map #(.NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH)) rmap_i (
    .interleave(interleave), .addr(rd_addr),
    .bank_idx(r_idx), .row(r_row), .out_of_range(r_oor)
  );

  logic do_write, rd_go;
  assign do_write = pk_valid && !w_oor;
  assign rd_go    = rd_en && !pk_valid;

  logic [BANK_W-1:0]           bank_q [NUM_BANKS];
  logic [NUM_BANKS*BANK_W-1:0] row_raw;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic sel_w;
    assign sel_w = do_write && (w_idx == IDX_W'(k));
    bcm_bank #(.BANK_W(BANK_W), .BANK_DEPTH(BANK_DEPTH)) bank_i (
      .clk(clk),
      .en(sel_w || (rd_go && !r_oor)),
      .we(sel_w),
      .row(sel_w ? w_row : r_row),
      .wdata(pk_data),
      .rdata(bank_q[k])
    );
    assign row_raw[k*BANK_W +: BANK_W] = bank_q[k];
  end

  logic             rdv_q, rde_q, done_q, err_q;
  logic             rdv_n, rde_n, done_n, err_n;
  logic [IDX_W-1:0] ridx_q, ridx_n;

  always_comb begin
    rdv_n  = rd_go;
    rde_n  = rd_go && r_oor;
    done_n = do_write;
    err_n  = pk_valid && w_oor;
    ridx_n = rd_go ? r_idx : ridx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q  <= 1'b0;
      rde_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ridx_q <= '0;
    end else begin
      rdv_q  <= rdv_n;
      rde_q  <= rde_n;
      done_q <= done_n;
      err_q  <= err_n;
      ridx_q <= ridx_n;
    end
  end

  logic good_rd;
  assign good_rd    = rdv_q && !rde_q;
  assign rd_valid   = rdv_q;
  assign rd_err     = rde_q;
  assign wr_done    = done_q;
  assign wr_err     = err_q;
  assign rd_data    = good_rd ? bank_q[ridx_q] : '0;
  assign rd_row     = good_rd ? row_raw : '0;
  assign rd_bank_id = 8'(BASE_ID) + 8'(ridx_q);

  assert_err_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (!wr_done && $past(pk_valid)));
  assert_rd_zero_on_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_valid && rd_data == '0 && rd_row == '0));
  assert_rd_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && pk_valid) |=> !rd_valid);
  assert_bank_id_span_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_err) |-> (rd_bank_id >= 8'(BASE_ID) &&
                               rd_bank_id <  8'(BASE_ID + NUM_BANKS)));
endmodule

// File: tb/bank_compose_mapper_tb_top.sv
`timescale 1ns/1ps
module bank_compose_mapper_tb_top;
  localparam int NB = 4;
  localparam int DP = 8;
  localparam int BW = 16;
  localparam int BASE = 5;
  localparam int CAP = NB * DP;

  logic clk = 1'b0;
  logic rst_n, interleave, xfer_start, byte_valid, rd_en;
  logic [15:0] xfer_addr, rd_addr;
  logic [7:0]  byte_data;
  logic wr_done, wr_err, rd_valid, rd_err;
  logic [BW-1:0]    rd_data;
  logic [NB*BW-1:0] rd_row;
  logic [7:0]       rd_bank_id;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] model [CAP];

  always #2.5 clk = ~clk;

  bank_compose_mapper #(.NUM_BANKS(NB), .BANK_DEPTH(DP), .BANK_W(BW), .BASE_ID(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .interleave(interleave), .xfer_start(xfer_start),
    .xfer_addr(xfer_addr), .byte_valid(byte_valid), .byte_data(byte_data),
    .wr_done(wr_done), .wr_err(wr_err), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data), .rd_row(rd_row),
    .rd_bank_id(rd_bank_id)
  );

  function automatic logic [15:0] pat(int a, int m);
    return 16'((a * 16'h0137 + 16'h0B05) ^ (m != 0 ? 16'h5A00 : 16'hC300));
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_byte(logic [7:0] b, bit st, logic [15:0] a);
    byte_valid = 1'b1; byte_data = b; xfer_start = st; xfer_addr = a;
    tick();
    byte_valid = 1'b0; xfer_start = 1'b0;
  endtask

  // word is formed at the edge of the high byte; wr_done/wr_err one edge later
  task automatic write_word(logic [15:0] d, bit st, logic [15:0] a, int dest, bit collide);
    bit inr;
    push_byte(d[7:0], st, a);
    push_byte(d[15:8], 1'b0, 16'h0);
    if (collide) begin rd_en = 1'b1; rd_addr = 16'(dest); end
    tick();
    rd_en = 1'b0;
    inr = dest < CAP;
    check(wr_done == inr, "R10", "wr_done", 64'(wr_done), 64'(inr));
    check(wr_err == !inr, "R5", "wr_err", 64'(wr_err), 64'(!inr));
    if (collide) check(rd_valid == 1'b0, "R8", "rd_valid on collision", 64'(rd_valid), 64'd0);
    if (inr) model[dest] = d;
  endtask

  task automatic read_check(int a, int m);
    int bidx, row;
    logic [NB*BW-1:0] exp_row;
    rd_en = 1'b1; rd_addr = 16'(a);
    tick();
    rd_en = 1'b0;
    check(rd_valid == 1'b1, "R7", "rd_valid", 64'(rd_valid), 64'd1);
    if (a < CAP) begin
      bidx = (m != 0) ? a % NB : a / DP;
      row  = (m != 0) ? a / NB : a % DP;
      for (int k = 0; k < NB; k++)
        exp_row[k*BW +: BW] = model[(m != 0) ? row*NB + k : k*DP + row];
      check(rd_err == 1'b0, "R6", "rd_err", 64'(rd_err), 64'd0);
      check(rd_data == model[a], (m != 0) ? "R3" : "R4", $sformatf("rd_data @%0d", a),
            64'(rd_data), 64'(model[a]));
      check(rd_row == exp_row, (m != 0) ? "R3" : "R4", $sformatf("rd_row @%0d", a),
            64'(rd_row), 64'(exp_row));
      check(rd_bank_id == 8'(BASE + bidx), "R9", $sformatf("rd_bank_id @%0d", a),
            64'(rd_bank_id), 64'(BASE + bidx));
    end else begin
      check(rd_err == 1'b1, "R6", "rd_err", 64'(rd_err), 64'd1);
      check(rd_data == '0 && rd_row == '0, "R6", "rd_data zero", 64'(rd_data), 64'd0);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    rst_n = 1'b0; interleave = 1'b1; xfer_start = 1'b0; xfer_addr = '0;
    byte_valid = 1'b0; byte_data = '0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) tick();
    check(!rd_valid && !rd_err && !wr_done && !wr_err, "R1", "flags in reset",
          64'({rd_valid, rd_err, wr_done, wr_err}), 64'd0);
    check(rd_data == '0 && rd_row == '0, "R1", "data in reset", 64'(rd_data), 64'd0);
    rst_n = 1'b1;
    tick();
    check(!rd_valid && !wr_done && !wr_err, "R1", "flags after release",
          64'({rd_valid, wr_done, wr_err}), 64'd0);

    for (int m = 1; m >= 0; m--) begin
      interleave = 1'(m);
      for (int a = 0; a < CAP; a++) write_word(pat(a, m), a == 0, 16'h0, a, 1'b0);
      for (int a = 0; a < CAP; a++) read_check(a, m);
      tick();
      check(rd_valid == 1'b0, "R7", "rd_valid idle", 64'(rd_valid), 64'd0);

      // crossing the top: last word lands, next one is dropped (R5)
      write_word(16'h1234 ^ 16'(m), 1'b1, 16'(CAP-1), CAP-1, 1'b0);
      write_word(16'hDEAD, 1'b0, 16'h0, CAP, 1'b0);
      read_check(0, m);
      read_check(CAP-1, m);
      write_word(16'hFACE, 1'b1, 16'(CAP+3), CAP+3, 1'b0);
      read_check(3, m);
      read_check(CAP+8, m);
      read_check(16'hFFFF, m);

      // restart mid-word: stale low byte dropped, same-cycle byte kept (R2)
      push_byte(8'h11, 1'b1, 16'd3);
      push_byte(8'h22, 1'b1, 16'd7);
      push_byte(8'h33, 1'b0, 16'd0);
      tick();
      check(wr_done == 1'b1, "R2", "restart word written", 64'(wr_done), 64'd1);
      model[7] = 16'h3322;
      read_check(7, m);
      read_check(3, m);
      read_check(4, m);

      // read colliding with a write (R8), then the write is visible
      write_word(16'hBEEF, 1'b1, 16'd9, 9, 1'b1);
      read_check(9, m);
    end

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung, actual running expected done");
      summary();
      $finish;
    end
  end
endmodule